// File: doc/BRIEF.md
# Address-Matching Receive DMA Engine

This engine sits between an incoming network word stream and a dual-port RAM. The stream carries address words and data words. Each address word is compared with the network addresses of every armed receive channel. Only a configurable bit slice of the address takes part in that compare. The data words that follow an address word are written into memory for the matching channel. Each channel has its own buffer base, pointer, received-word counter and remaining-word count, so several transfers can wait for data at the same time and arrive interleaved.

When a channel has stored its programmed number of words, it disarms itself and raises its own sticky interrupt. If an address word matches no armed channel, the engine stops accepting stream words. It holds that address on an output and raises an unknown-address interrupt. Software then arms a channel whose network address matches the held one. Reception resumes into that channel, and the usual completion interrupt follows. Channel parameters are loaded through a side load port, and each channel's progress can be read back through a side read port.

Top module: `rxdma_engine`

## Requirements
- R1: After reset, rx_ready is 1, and irq, unk_irq, mem_we and rd_armed are all 0.
- R2: An address word selects the armed channel whose net address equals the word on bits CMP_HI down to CMP_LO. Bits outside that slice are ignored. When several armed channels match, the lowest channel index wins.
- R3: The data words that follow a matched address word are written to consecutive word addresses starting at the channel's base, in arrival order. Every write has all byte enables set to 1.
- R4: While mem_wait is 1 and a write is pending, mem_addr, mem_wdata and mem_we hold steady and rx_ready is 0.
- R5: irq[i] is set by the clock edge at which memory accepts channel i's final write. At that point the channel is disarmed, so it no longer matches. irq[i] stays set until irq_clr[i] is pulsed.
- R6: For the channel picked by rd_sel, rd_count equals the number of data words accepted since that channel was loaded, and rd_ptr equals the base plus that count.
- R7: An address word that matches no armed channel sets unk_irq and places the word on unk_addr. rx_ready then stays 0 until a channel matching that address is loaded. After the load, unk_irq clears and the following data words go to that channel.
- R8: A data word that arrives when no channel is selected is accepted and dropped, with no memory write. This covers a data word after a channel has completed.
- R9: Channels are switched by new address words in any order. Each channel resumes from its own pointer.
- R10: cfg_load arms the channel named by cfg_sel. It sets the pointer to cfg_base, the received count to 0, the remaining count to cfg_amount (which must be at least 1) and the net address to cfg_net.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Stream word present |
| rx_is_addr | input | 1 | 1 = the stream word is an address word, 0 = a data word |
| rx_word | input | DW | Stream word |
| rx_ready | output | 1 | Engine can take a stream word |
| cfg_load | input | 1 | Arm (load) a channel |
| cfg_sel | input | CHW | Channel to load |
| cfg_base | input | AW | Buffer base word address |
| cfg_net | input | DW | Network address of the channel |
| cfg_amount | input | CW | Words to receive (at least 1) |
| irq_clr | input | NCH | Per-channel interrupt clear |
| irq | output | NCH | Per-channel completion interrupt |
| unk_irq | output | 1 | Unknown address pending |
| unk_addr | output | DW | Held unknown address |
| rd_sel | input | CHW | Channel shown on the read port |
| rd_ptr | output | AW | Current pointer of the selected channel |
| rd_count | output | CW | Words received by the selected channel |
| rd_armed | output | 1 | Selected channel is armed |
| mem_addr | output | AW | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | DW/8 | Byte enables |
| mem_wdata | output | DW | Memory write data |
| mem_wait | input | 1 | Memory wait-request |

## Verification
The bench sweeps every channel against every amount from 1 to 6. It runs each sweep twice: once with free memory, once under pseudo-random wait-requests. A pointer that stepped wrongly, or a write lost or repeated under stall, would show up as wrong RAM contents or a wrong count. It sends address words that differ from a channel's net address only outside the compare slice, and pairs of channels with the same net address. A design that compared the whole word, or picked the wrong channel when two match, would route data to the wrong buffer. It also covers an unknown address that is held until a later load, a data word after completion, which must leave memory untouched, and a reload in the middle of a transfer, which must restart the pointer and count.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
   // index width for a channel count, never below one bit
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rxdma_match.sv
module rxdma_match #(
   parameter int NCH    = 8,
   parameter int DW     = 32,
   parameter int CMP_LO = 0,
   parameter int CMP_HI = 27,
   localparam int CHW   = rxdma_pkg::idx_w(NCH)
) (
   input  logic [NCH*DW-1:0] net_flat,
   input  logic [NCH-1:0]    armed,
   input  logic [DW-1:0]     key,
   output logic              hit,
   output logic [CHW-1:0]    idx
);
   logic [NCH-1:0] eq;

   for (genvar i = 0; i < NCH; i++) begin : g_cmp
      assign eq[i] = armed[i] &&
         (net_flat[i*DW+CMP_HI : i*DW+CMP_LO] == key[CMP_HI:CMP_LO]);
   end

   // lowest index wins
   always_comb begin
      idx = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (eq[i]) idx = CHW'(i);
      end
   end
   assign hit = |eq;
endmodule

// File: rtl/rxdma_chan.sv
module rxdma_chan #(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic [DW-1:0] net,
   input  logic [CW-1:0] amount,
   input  logic          step,
   input  logic          done_set,
   input  logic          irq_clr,
   output logic          armed,
   output logic [DW-1:0] net_q,
   output logic [AW-1:0] ptr,
   output logic [CW-1:0] count,
   output logic          last,
   output logic          irq
);
   logic [CW-1:0] remain;

   assign last = (remain == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         net_q  <= '0;
         ptr    <= '0;
         count  <= '0;
         remain <= '0;
      end else if (load) begin
         armed  <= 1'b1;
         net_q  <= net;
         ptr    <= base;
         count  <= '0;
         remain <= amount;
      end else if (step) begin
         ptr    <= ptr + AW'(1);
         count  <= count + CW'(1);
         remain <= remain - CW'(1);
         if (last) armed <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        irq <= 1'b0;
      else if (done_set) irq <= 1'b1;
      else if (irq_clr)  irq <= 1'b0;
   end

   p_step_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> armed);
endmodule

// File: rtl/rxdma_wr.sv
module rxdma_wr #(
   parameter int AW  = 16,
   parameter int DW  = 32,
   parameter int CHW = 3,
   localparam int BEW = DW / 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push,
   input  logic [AW-1:0]  push_addr,
   input  logic [DW-1:0]  push_data,
   input  logic           push_last,
   input  logic [CHW-1:0] push_ch,
   input  logic           mem_wait,
   output logic           stall,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   output logic [BEW-1:0] mem_be,
   output logic           done,
   output logic [CHW-1:0] done_ch
);
   logic wr_v, wr_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_v      <= 1'b0;
         wr_last   <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         done_ch   <= '0;
      end else if (push) begin
         wr_v      <= 1'b1;
         wr_last   <= push_last;
         mem_addr  <= push_addr;
         mem_wdata <= push_data;
         done_ch   <= push_ch;
      end else if (!mem_wait) begin
         wr_v <= 1'b0;
      end
   end

   assign mem_we = wr_v;
   assign mem_be = {BEW{1'b1}};
   assign stall  = wr_v && mem_wait;
   assign done   = wr_v && !mem_wait && wr_last;

   p_be_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_be == {BEW{1'b1}}));
   p_hold_on_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_wait) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));
   p_no_push_in_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !(wr_v && mem_wait));
endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine #(
   parameter int DW     = 32,
   parameter int AW     = 16,
   parameter int CW     = 16,
   parameter int NCH    = 8,
   parameter int CMP_LO = 0,
   parameter int CMP_HI = 27,
   localparam int CHW   = rxdma_pkg::idx_w(NCH),
   localparam int BEW   = DW / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic              rx_is_addr,
   input  logic [DW-1:0]     rx_word,
   output logic              rx_ready,
   input  logic              cfg_load,
   input  logic [CHW-1:0]    cfg_sel,
   input  logic [AW-1:0]     cfg_base,
   input  logic [DW-1:0]     cfg_net,
   input  logic [CW-1:0]     cfg_amount,
   input  logic [NCH-1:0]    irq_clr,
   output logic [NCH-1:0]    irq,
   output logic              unk_irq,
   output logic [DW-1:0]     unk_addr,
   input  logic [CHW-1:0]    rd_sel,
   output logic [AW-1:0]     rd_ptr,
   output logic [CW-1:0]     rd_count,
   output logic              rd_armed,
   output logic [AW-1:0]     mem_addr,
   output logic              mem_we,
   output logic [BEW-1:0]    mem_be,
   output logic [DW-1:0]     mem_wdata,
   input  logic              mem_wait
);
   if (DW % 8 != 0)                begin : g_bad_dw  $error("DW must be whole bytes"); end
   if (CMP_HI >= DW)               begin : g_bad_hi  $error("CMP_HI beyond word"); end
   if (CMP_LO < 0 || CMP_LO > CMP_HI) begin : g_bad_lo $error("bad compare slice"); end
   if (NCH < 1)                    begin : g_bad_n   $error("need a channel"); end

   logic [NCH-1:0]    armed, last, step, done_set;
   logic [NCH*DW-1:0] net_flat;
   logic [AW-1:0]     ptr_a [NCH];
   logic [CW-1:0]     cnt_a [NCH];
   logic [CHW-1:0]    cur_ch, hit_idx, done_ch;
   logic              cur_v, unk_pend, hit, stall, done, acc, push, cur_last;
   logic [DW-1:0]     key;
   logic [AW-1:0]     cur_ptr;

   assign rx_ready = !unk_pend && !stall;
   assign acc      = rx_valid && rx_ready;
   assign push     = acc && !rx_is_addr && cur_v;
   assign key      = unk_pend ? unk_addr : rx_word;
   assign unk_irq  = unk_pend;
   assign cur_last = (int'(cur_ch) < NCH) ? last[cur_ch]  : 1'b0;
   assign cur_ptr  = (int'(cur_ch) < NCH) ? ptr_a[cur_ch] : '0;

   rxdma_match #(.NCH(NCH), .DW(DW), .CMP_LO(CMP_LO), .CMP_HI(CMP_HI)) u_match (
      .net_flat(net_flat), .armed(armed), .key(key), .hit(hit), .idx(hit_idx));

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign step[i]     = push && (cur_ch == CHW'(i));
      assign done_set[i] = done && (done_ch == CHW'(i));
      rxdma_chan #(.AW(AW), .CW(CW), .DW(DW)) u_chan (
         .clk(clk), .rst_n(rst_n),
         .load(cfg_load && (cfg_sel == CHW'(i))),
         .base(cfg_base), .net(cfg_net), .amount(cfg_amount),
         .step(step[i]), .done_set(done_set[i]), .irq_clr(irq_clr[i]),
         .armed(armed[i]), .net_q(net_flat[i*DW +: DW]),
         .ptr(ptr_a[i]), .count(cnt_a[i]), .last(last[i]), .irq(irq[i]));
   end

   rxdma_wr #(.AW(AW), .DW(DW), .CHW(CHW)) u_wr (
      .clk(clk), .rst_n(rst_n), .push(push), .push_addr(cur_ptr),
      .push_data(rx_word), .push_last(cur_last), .push_ch(cur_ch),
      .mem_wait(mem_wait), .stall(stall), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_be(mem_be), .done(done), .done_ch(done_ch));

   // channel selection and unknown-address hold
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_ch   <= '0;
         cur_v    <= 1'b0;
         unk_pend <= 1'b0;
         unk_addr <= '0;
      end else if (unk_pend) begin
         if (hit) begin
            unk_pend <= 1'b0;
            cur_ch   <= hit_idx;
            cur_v    <= 1'b1;
         end
      end else if (acc && rx_is_addr) begin
         if (hit) begin
            cur_ch <= hit_idx;
            cur_v  <= 1'b1;
         end else begin
            cur_v    <= 1'b0;
            unk_pend <= 1'b1;
            unk_addr <= rx_word;
         end
      end else if (push && cur_last) begin
         cur_v <= 1'b0;
      end
   end

   always_comb begin
      rd_ptr   = '0;
      rd_count = '0;
      rd_armed = 1'b0;
      if (int'(rd_sel) < NCH) begin
         rd_ptr   = ptr_a[rd_sel];
         rd_count = cnt_a[rd_sel];
         rd_armed = armed[rd_sel];
      end
   end

   p_stall_backpressure_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_wait) |-> !rx_ready);
   p_unknown_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      unk_irq |-> !rx_ready);
   p_irq_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq & ~$past(irq)) != '0) |-> $past(mem_we && !mem_wait));
   p_onehot_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done_set));
endmodule

// File: tb/tb_rxdma_engine.sv
module tb_rxdma_engine;
   localparam int DW = 32, AW = 8, CW = 8, NCH = 4, LO = 4, HI = 11, CHW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic rx_valid = 0, rx_is_addr = 0, rx_ready;
   logic [DW-1:0] rx_word = '0;
   logic cfg_load = 0;
   logic [CHW-1:0] cfg_sel = '0, rd_sel = '0;
   logic [AW-1:0] cfg_base = '0, rd_ptr, mem_addr;
   logic [DW-1:0] cfg_net = '0, unk_addr, mem_wdata;
   logic [CW-1:0] cfg_amount = '0, rd_count;
   logic [NCH-1:0] irq_clr = '0, irq;
   logic unk_irq, rd_armed, mem_we, mem_wait = 0;
   logic [3:0] mem_be;

   always #2 clk = ~clk;

   rxdma_engine #(.DW(DW), .AW(AW), .CW(CW), .NCH(NCH), .CMP_LO(LO), .CMP_HI(HI)) dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_is_addr(rx_is_addr),
      .rx_word(rx_word), .rx_ready(rx_ready), .cfg_load(cfg_load), .cfg_sel(cfg_sel),
      .cfg_base(cfg_base), .cfg_net(cfg_net), .cfg_amount(cfg_amount),
      .irq_clr(irq_clr), .irq(irq), .unk_irq(unk_irq), .unk_addr(unk_addr),
      .rd_sel(rd_sel), .rd_ptr(rd_ptr), .rd_count(rd_count), .rd_armed(rd_armed),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_wait(mem_wait));

   int checks = 0, fails = 0, nwr = 0, viol = 0;
   bit stall_en = 0, done_flag = 0;
   logic [DW-1:0] ram [256];
   logic [15:0] lfsr = 16'hACE1;

   always @(posedge clk) if (mem_we && !mem_wait) begin
      ram[mem_addr] <= mem_wdata;
      nwr <= nwr + 1;
   end

   always @(negedge clk) begin
      lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_wait <= stall_en && lfsr[0] && !lfsr[3];
   end

   // R4 monitor: stalled write must block the stream and all write outputs must be full-byte
   always @(negedge clk) begin
      #1;
      if (rst_n && mem_we && mem_wait && rx_ready) viol++;
      if (rst_n && mem_we && mem_be != 4'hF) viol++;
   end

   function automatic logic [DW-1:0] net_of(input int ch);
      return 32'(8'h10 + ch) << LO;
   endfunction
   function automatic logic [DW-1:0] dat_of(input int ch, input int rnd, input int i);
      return {8'hA0 + 8'(ch), 8'(rnd), 16'(i)};
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic load(input int ch, input int base, input int amt, input logic [DW-1:0] net);
      @(negedge clk);
      cfg_load = 1; cfg_sel = CHW'(ch); cfg_base = AW'(base);
      cfg_amount = CW'(amt); cfg_net = net;
      @(negedge clk);
      cfg_load = 0;
   endtask

   task automatic wait_take();
      #1;
      while (!rx_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      #1 rx_valid = 0;
   endtask

   task automatic put(input logic [DW-1:0] w, input bit is_addr);
      @(negedge clk);
      rx_valid = 1; rx_is_addr = is_addr; rx_word = w;
      wait_take();
   endtask

   task automatic settle();
      int n = 0;
      @(negedge clk); #1;
      while (mem_we && n < 300) begin @(negedge clk); #1; n++; end
      @(negedge clk);
   endtask

   task automatic clr_all();
      @(negedge clk); irq_clr = '1;
      @(negedge clk); irq_clr = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int w0;
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk(rx_ready == 1, "R1 rx_ready", rx_ready, 1);
      chk(irq == 0 && unk_irq == 0, "R1 irq", {irq, unk_irq}, 0);
      chk(mem_we == 0 && rd_armed == 0, "R1 we/armed", {mem_we, rd_armed}, 0);
      @(negedge clk) rst_n = 1;

      // R3 R5 R6 sweep, free memory then stalled memory (R4)
      for (int pass = 0; pass < 2; pass++) begin
         stall_en = (pass == 1);
         for (int ch = 0; ch < NCH; ch++) begin
            for (int amt = 1; amt <= 6; amt++) begin
               int rnd = pass * 16 + amt;
               w0 = nwr;
               load(ch, ch * 40, amt, net_of(ch));
               rd_sel = CHW'(ch);
               #1 chk(rd_armed == 1 && rd_count == 0, "R10 armed after load", rd_count, 0);
               // outside-slice bits differ from the programmed net address (R2)
               put(net_of(ch) | 32'hF5A0_F00F, 1);
               for (int i = 0; i < amt; i++) put(dat_of(ch, rnd, i), 0);
               settle();
               for (int i = 0; i < amt; i++)
                  chk(ram[ch*40+i] === dat_of(ch, rnd, i), "R3 data", ram[ch*40+i], dat_of(ch, rnd, i));
               chk(nwr - w0 == amt, "R3 write count", nwr - w0, amt);
               chk(irq == NCH'(1 << ch), "R5 irq", irq, 1 << ch);
               chk(rd_count == amt && rd_ptr == AW'(ch*40+amt), "R6 ptr/count", {rd_ptr, rd_count}, {AW'(ch*40+amt), CW'(amt)});
               chk(rd_armed == 0, "R5 disarm", rd_armed, 0);
               @(negedge clk); #1;
               chk(irq == NCH'(1 << ch), "R5 sticky", irq, 1 << ch);
               clr_all(); #1;
               chk(irq == 0, "R5 clear", irq, 0);
            end
         end
      end
      chk(viol == 0, "R4 backpressure/R3 be", viol, 0);
      stall_en = 0;

      // R8 data after completion is dropped
      w0 = nwr;
      put(32'hDEAD_0001, 0);
      put(32'hDEAD_0002, 0);
      settle();
      chk(nwr == w0, "R8 no write", nwr - w0, 0);

      // R2 priority: channels 1 and 3 share a net address
      load(1, 100, 1, net_of(1));
      load(3, 110, 1, net_of(1));
      put(net_of(1), 1); put(32'h1111_1111, 0);
      settle();
      chk(irq == 4'b0010 && ram[100] == 32'h1111_1111, "R2 lowest index wins", irq, 4'b0010);
      put(net_of(1), 1); put(32'h3333_3333, 0);
      settle();
      chk(irq == 4'b1010 && ram[110] == 32'h3333_3333, "R2 second match", irq, 4'b1010);
      clr_all();

      // R9 interleaving
      load(0, 120, 3, net_of(0));
      load(2, 130, 2, net_of(2));
      put(net_of(0), 1); put(32'hC0_0000, 0); put(32'hC0_0001, 0);
      put(net_of(2), 1); put(32'hC2_0000, 0);
      put(net_of(0), 1); put(32'hC0_0002, 0);
      put(net_of(2), 1); put(32'hC2_0001, 0);
      settle();
      for (int i = 0; i < 3; i++)
         chk(ram[120+i] == 32'hC0_0000 + i, "R9 ch0 order", ram[120+i], 32'hC0_0000 + i);
      for (int i = 0; i < 2; i++)
         chk(ram[130+i] == 32'hC2_0000 + i, "R9 ch2 order", ram[130+i], 32'hC2_0000 + i);
      chk(irq == 4'b0101, "R9 both irq", irq, 4'b0101);
      clr_all();

      // R7 unknown address held until a matching channel is loaded
      put(32'h7000_0559, 1);
      @(negedge clk); #1;
      chk(unk_irq == 1, "R7 unk_irq", unk_irq, 1);
      chk(unk_addr == 32'h7000_0559, "R7 unk_addr", unk_addr, 32'h7000_0559);
      chk(rx_ready == 0, "R7 blocked", rx_ready, 0);
      w0 = nwr;
      rx_valid = 1; rx_is_addr = 0; rx_word = 32'hBEEF_0000;
      repeat (6) @(negedge clk);
      #1 chk(nwr == w0 && unk_irq == 1, "R7 still held", nwr - w0, 0);
      load(3, 140, 2, 32'h0000_0550);
      wait_take();
      put(32'hBEEF_0001, 0);
      settle();
      chk(unk_irq == 0, "R7 released", unk_irq, 0);
      chk(ram[140] == 32'hBEEF_0000 && ram[141] == 32'hBEEF_0001, "R7 data stored", ram[141], 32'hBEEF_0001);
      chk(irq == 4'b1000, "R7 completion irq", irq, 4'b1000);
      clr_all();

      // R10 reload mid transfer
      load(0, 150, 4, net_of(0));
      put(net_of(0), 1); put(32'h5, 0); put(32'h6, 0);
      settle();
      rd_sel = 0;
      load(0, 200, 1, net_of(0));
      #1 chk(rd_ptr == 200 && rd_count == 0, "R10 reload", rd_ptr, 200);
      put(net_of(0), 1); put(32'h77, 0);
      settle();
      chk(ram[200] == 32'h77 && irq == 4'b0001, "R10 new base", ram[200], 32'h77);

      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule